// File: doc/BRIEF.md
# Edge-Select Input Capture Unit

This block watches one asynchronous input pin and records when a chosen transition happens on it. It brings the pin into the clock domain through a two-flop synchroniser. It can optionally pass the pin through a debounce filter. When a transition of the selected kind is seen, the block copies the value of an external free-running counter into its capture register. It also raises a capture flag. The flag is cleared by a write-1 strobe, and it drives an interrupt output that is gated by an enable.

A mode input turns the unit into capture-then-reset. In that mode the same event also sends a one-cycle clear request to the counter that owns the count. The flag also works as a lock: while it is set, a further event is thrown away. The stored value stays intact until software clears the flag.

Top module: `cap_unit`

## Requirements
- R1: After reset the capture data is 0, and the flag, the interrupt and the clear request are all 0.
- R2: The edge select is decoded as 2'b00 falling, 2'b01 rising, 2'b10 either edge and 2'b11 no detection. Only a matching transition is an event. With the debounce filter off, the event's results appear on the outputs three clock edges after the pin changes.
- R3: While the capture enable is low, transitions produce no event. Re-enabling the unit creates no event from a transition that happened while it was disabled.
- R4: An accepted event loads the counter value present at the capturing clock edge into the capture data, and it sets the flag.
- R5: With the reset mode high, an accepted event drives the clear request high for exactly one cycle, the same cycle the capture data changes. With the reset mode low, the clear request stays low.
- R6: An event that arrives while the flag is set is dropped. The capture data keeps its value, the flag stays set and no clear request is issued.
- R7: A one-cycle pulse on the clear-flag input clears the flag at the next edge. If an event lands on that same edge, the event wins: the flag stays set and the data is loaded.
- R8: The interrupt output is high exactly when both the flag and the interrupt enable are high. It follows the interrupt enable with no delay.
- R9: With the debounce filter on, a new level is accepted only after the synchronised input has held it for 3 consecutive samples. A pulse shorter than 3 cycles causes no event. A pulse of exactly 3 cycles causes an event whose results appear six clock edges after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | CNT_W | Current value of the external counter |
| cap_en | input | 1 | Capture enable |
| edge_sel | input | 2 | Transition kind: 00 fall, 01 rise, 10 either, 11 none |
| reset_mode | input | 1 | 1: capture and then request a counter clear |
| db_en | input | 1 | Route the pin through the debounce filter |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-1 strobe that clears the capture flag |
| cap_pin | input | 1 | Asynchronous capture input |
| cap_data | output | CNT_W | Captured counter value |
| cap_flag | output | 1 | Capture flag |
| cap_irq | output | 1 | Gated capture interrupt |
| cnt_clr | output | 1 | One-cycle counter clear request |

## Verification
A pin change made between clock edges reaches the outputs at the third following edge when the filter is off, and at the sixth when it is on. The interrupt output is combinational and follows its enable in the same cycle. The bench drives every input on the falling clock edge. It samples the outputs one time unit after a falling edge: once a cycle before the due edge, to prove nothing arrives early, then at the due edge, then one cycle after it, to prove the clear request has already dropped. The expected captured value is the counter value present at the due edge, and the bench recomputes it from its own cycle count.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_ANY  = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;

  // Decide whether an observed transition matches the selected kind.
  function automatic logic edge_match(edge_sel_e sel, logic rise, logic fall);
    case (sel)
      EDGE_FALL: return fall;
      EDGE_RISE: return rise;
      EDGE_ANY:  return rise | fall;
      default:   return 1'b0;
    endcase
  endfunction

  // An event is taken when the flag is free or is being cleared on the same edge.
  function automatic logic event_taken(logic hit, logic flag, logic clr);
    return hit & (~flag | clr);
  endfunction

endpackage

// File: rtl/cap_sync.sv
`timescale 1ns/1ps
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cap_debounce.sv
`timescale 1ns/1ps
module cap_debounce #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int HW = (LEN > 1) ? LEN - 1 : 1;

  logic [HW-1:0] hist;
  logic          lvl;
  logic          all_hi;
  logic          all_lo;

  // Current sample plus HW earlier samples must agree.
  assign all_hi = din & (&hist);
  assign all_lo = ~din & ~(|hist);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      lvl  <= 1'b0;
    end else begin
      hist <= (hist << 1) | HW'(din);
      if (all_hi)      lvl <= 1'b1;
      else if (all_lo) lvl <= 1'b0;
    end
  end

  assign dout = lvl;
endmodule

// File: rtl/cap_edge.sv
`timescale 1ns/1ps
module cap_edge
  import cap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl,
  input  logic      en,
  input  edge_sel_e sel,
  output logic      rise,
  output logic      fall,
  output logic      hit
);
  logic prev;

  // prev tracks the level even while disabled, so enabling makes no false edge.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
  assign hit  = en & edge_match(sel, rise, fall);
endmodule

// File: rtl/cap_unit.sv
`timescale 1ns/1ps
module cap_unit
  import cap_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2,
  parameter int DB_LEN      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cap_en,
  input  logic [1:0]       edge_sel,
  input  logic             reset_mode,
  input  logic             db_en,
  input  logic             irq_en,
  input  logic             flag_clr,
  input  logic             cap_pin,
  output logic [CNT_W-1:0] cap_data,
  output logic             cap_flag,
  output logic             cap_irq,
  output logic             cnt_clr
);
  // Named internal events, visible to the bound checker.
  logic pin_sync;
  logic pin_filt;
  logic pin_lvl;
  logic evt_rise;
  logic evt_fall;
  logic evt_hit;
  logic evt_take;
  logic evt_drop;

  cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cap_pin),
    .q     (pin_sync)
  );

  cap_debounce #(.LEN(DB_LEN)) u_db (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_sync),
    .dout  (pin_filt)
  );

  assign pin_lvl = db_en ? pin_filt : pin_sync;

  cap_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (pin_lvl),
    .en    (cap_en),
    .sel   (edge_sel_e'(edge_sel)),
    .rise  (evt_rise),
    .fall  (evt_fall),
    .hit   (evt_hit)
  );

  assign evt_take = event_taken(evt_hit, cap_flag, flag_clr);
  assign evt_drop = evt_hit & ~evt_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_data <= '0;
      cap_flag <= 1'b0;
      cnt_clr  <= 1'b0;
    end else begin
      cnt_clr <= evt_take & reset_mode;
      if (evt_take) begin
        cap_data <= cnt_val;
        cap_flag <= 1'b1;
      end else if (flag_clr) begin
        cap_flag <= 1'b0;
      end
    end
  end

  assign cap_irq = cap_flag & irq_en;
endmodule

// File: rtl/cap_unit_chk.sv
`timescale 1ns/1ps
module cap_unit_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_val,
  input logic             cap_en,
  input logic             reset_mode,
  input logic             irq_en,
  input logic             flag_clr,
  input logic [CNT_W-1:0] cap_data,
  input logic             cap_flag,
  input logic             cap_irq,
  input logic             cnt_clr,
  input logic             evt_hit
);
  // R4
  capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_flag) |-> cap_data == $past(cnt_val));

  // R6
  drop_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_flag && !flag_clr |=> $stable(cap_data) && !cnt_clr);

  // R5
  clear_req_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |-> cap_flag && $past(reset_mode));

  // R3
  disabled_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> !$rose(cap_flag));

  // R7
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !evt_hit |=> !cap_flag);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq |-> cap_flag && irq_en);
endmodule

bind cap_unit cap_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_val    (cnt_val),
  .cap_en     (cap_en),
  .reset_mode (reset_mode),
  .irq_en     (irq_en),
  .flag_clr   (flag_clr),
  .cap_data   (cap_data),
  .cap_flag   (cap_flag),
  .cap_irq    (cap_irq),
  .cnt_clr    (cnt_clr),
  .evt_hit    (evt_hit)
);

// File: tb/cap_unit_test.sv
`timescale 1ns/1ps
module cap_unit_test;
  localparam int CW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cnt_val;
  logic          cap_en = 1'b0;
  logic [1:0]    edge_sel = 2'b00;
  logic          reset_mode = 1'b0;
  logic          db_en = 1'b0;
  logic          irq_en = 1'b0;
  logic          flag_clr = 1'b0;
  logic          cap_pin = 1'b0;
  logic [CW-1:0] cap_data;
  logic          cap_flag;
  logic          cap_irq;
  logic          cnt_clr;

  int  cyc = 0;
  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 1'b0;
  logic [CW-1:0] exp_data = '0;

  always #2 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;
  assign cnt_val = CW'(cyc * 37 + 11);

  cap_unit uut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cap_en(cap_en),
    .edge_sel(edge_sel), .reset_mode(reset_mode), .db_en(db_en),
    .irq_en(irq_en), .flag_clr(flag_clr), .cap_pin(cap_pin),
    .cap_data(cap_data), .cap_flag(cap_flag), .cap_irq(cap_irq),
    .cnt_clr(cnt_clr)
  );

  function automatic logic [CW-1:0] cnt_at(int c);
    return CW'(c * 37 + 11);
  endfunction

  function automatic bit sel_wants(int s, bit rising);
    if (s == 2) return 1'b1;
    if (s == 1) return rising;
    if (s == 0) return !rising;
    return 1'b0;
  endfunction

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
    chk("R7 flag cleared", 32'(cap_flag), 32'd0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int c0;
    int lat;
    bit hit;
    // R1 reset state
    settle(3);
    chk("R1 data", 32'(cap_data), 32'd0);
    chk("R1 flag", 32'(cap_flag), 32'd0);
    chk("R1 irq", 32'(cap_irq), 32'd0);
    chk("R1 clr", 32'(cnt_clr), 32'd0);
    rst_n = 1'b1;
    cap_en = 1'b1;
    settle(2);

    // Sweep: filter, edge select, reset mode, direction (R2 R4 R5 R8 R9)
    for (int db = 0; db < 2; db++) begin
      db_en = 1'(db);
      lat = db ? 6 : 3;
      for (int s = 0; s < 4; s++) begin
        for (int rm = 0; rm < 2; rm++) begin
          for (int d = 0; d < 2; d++) begin
            edge_sel   = 2'(s);
            reset_mode = 1'(rm);
            irq_en     = 1'((s + rm + d) % 2);
            hit        = sel_wants(s, d == 0);
            cap_pin    = (d == 0);
            c0         = cyc;
            settle(lat - 1);
            chk("R2 not early", 32'(cap_flag), 32'd0);
            tick();
            if (hit) exp_data = cnt_at(c0 + lat - 1);
            chk(db ? "R9 filtered flag" : "R2 flag", 32'(cap_flag), 32'(hit));
            chk("R4 data", 32'(cap_data), 32'(exp_data));
            chk("R5 clear request", 32'(cnt_clr), 32'(hit && rm == 1));
            chk("R8 irq", 32'(cap_irq), 32'(hit && irq_en));
            tick();
            chk("R5 one cycle", 32'(cnt_clr), 32'd0);
            settle(6);
            if (hit) clear_flag();
          end
        end
      end
    end

    // R6 drop while flag is set
    db_en = 1'b0; edge_sel = 2'b10; reset_mode = 1'b1; irq_en = 1'b1;
    cap_pin = 1'b1; c0 = cyc;
    settle(3);
    exp_data = cnt_at(c0 + 2);
    chk("R4 first capture", 32'(cap_data), 32'(exp_data));
    settle(4);
    cap_pin = 1'b0;
    settle(2);
    chk("R6 no clear early", 32'(cnt_clr), 32'd0);
    tick();
    chk("R6 data kept", 32'(cap_data), 32'(exp_data));
    chk("R6 flag kept", 32'(cap_flag), 32'd1);
    chk("R6 no clear request", 32'(cnt_clr), 32'd0);
    irq_en = 1'b0; #1;
    chk("R8 irq follows enable low", 32'(cap_irq), 32'd0);
    irq_en = 1'b1; #1;
    chk("R8 irq follows enable high", 32'(cap_irq), 32'd1);
    settle(4);

    // R7 clear on the same edge as an event: the event wins
    edge_sel = 2'b01; reset_mode = 1'b0;
    cap_pin = 1'b1; c0 = cyc;
    tick();
    tick();
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
    exp_data = cnt_at(c0 + 2);
    chk("R7 event wins flag", 32'(cap_flag), 32'd1);
    chk("R7 event wins data", 32'(cap_data), 32'(exp_data));
    settle(4);
    clear_flag();
    cap_pin = 1'b0;
    settle(6);

    // R3 disabled: no capture, and no event on re-enable
    cap_en = 1'b0; edge_sel = 2'b10;
    cap_pin = 1'b1;
    settle(5);
    chk("R3 disabled flag", 32'(cap_flag), 32'd0);
    chk("R3 disabled data", 32'(cap_data), 32'(exp_data));
    cap_en = 1'b1;
    settle(4);
    chk("R3 re-enable no event", 32'(cap_flag), 32'd0);
    cap_pin = 1'b0;
    settle(3);
    chk("R3 enabled again", 32'(cap_flag), 32'd1);
    exp_data = cap_data;
    clear_flag();
    settle(4);

    // R9 glitch rejection and exact 3-cycle acceptance
    db_en = 1'b1; edge_sel = 2'b01;
    cap_pin = 1'b1;
    tick();
    tick();
    cap_pin = 1'b0;
    settle(10);
    chk("R9 short pulse rejected", 32'(cap_flag), 32'd0);
    cap_pin = 1'b1; c0 = cyc;
    tick(); tick(); tick();
    cap_pin = 1'b0;
    tick(); tick();
    chk("R9 not early", 32'(cap_flag), 32'd0);
    tick();
    chk("R9 three-cycle pulse taken", 32'(cap_flag), 32'd1);
    chk("R9 data", 32'(cap_data), 32'(cnt_at(c0 + 5)));
    settle(8);
    clear_flag();

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule